// File: doc/BRIEF.md
# Programmable frame pulse generator

This block drives eight output channels. Each channel is timed against a common frame reference. The reference is built by a free-running phase counter that wraps every 2^PHASE_W clocks, which is 4096 by default. At a 32.768 MHz clock this gives an 8 kHz frame. In pulse mode, a channel asserts its output once in every selected frame. Software sets the phase at which the pulse starts, with single-clock resolution. It also sets the pulse width in clocks, an output inversion, and a frame divider that lets the pulse fire only on every Nth frame.

A channel can also be switched into general-purpose mode. In that mode its pin is a plain register bit with a programmable output enable. The pin level can be read back through a per-bit visibility mask. The last channel has a third use: it can carry the output of a 16-bit reload timer.

All settings are made through a byte-wide write/read register port. Start phase, width and divider are staged in the register file. They move into the channel at the next frame boundary, so a change never cuts or doubles a pulse in the middle of a frame.

Top module: `fpulse_gen`

## Requirements
- R1: Let the phase counter hold 0 in the cycle after reset is released, and advance by one each clock modulo 2^PHASE_W. If the phase equals a channel's active start value, and that channel's width W is nonzero, then the channel's pulse is high for exactly the following W cycles.
- R2: A width of 0 produces no pulse. A pulse that starts near the end of a frame continues across the frame boundary. The last phase of a frame is also a valid start value.
- R3: Control bit 1 of a channel (register offset 3) inverts that channel's output in pulse mode and in timer mode.
- R4: Control bits 7:4 of a channel hold a rate code N. The pulse fires in the first frame in which the setting is active, and then in every (N+1)th frame after that.
- R5: Writes to start phase, width and rate code take effect at the next frame boundary. A frame already in progress keeps its old start phase.
- R6: Each channel has a 4-byte block at address 4·c. Offset +0 holds the low start byte and +1 holds the high start byte. Start bits at or above PHASE_W are not stored and read as zero; with the default of 12 bits, the top nibble of the high byte is always zero.
- R7: Control bit 0 selects general-purpose mode. In that mode ch_out follows the data register (0x20) and ch_oe follows the direction register (0x21, 1 = drive). A channel in pulse mode always has ch_oe high.
- R8: Reading 0x20 returns, for each bit, mask (0x22) AND (the data-register bit if the direction bit is 1, otherwise the ch_in bit).
- R9: Setting bit 0 of 0x23 hands the last channel to a timer. The timer reload value is split across 0x24 (low byte) and 0x25 (high byte). The timer emits one-cycle pulses spaced reload+1 cycles apart.
- R10: Width (+2), control (+3), timer enable and both reload bytes read back as written. After reset, every register reads 0, ch_out is 0 and ch_oe is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from addr |
| ch_in | input | NCH | Pin levels seen by general-purpose reads |
| ch_out | output | NCH | Channel output levels |
| ch_oe | output | NCH | Channel output enables |

## Verification
Two events can land on the same clock edge: a pulse start and the frame-boundary reload of staged settings plus the divider step. The bench provokes this with a start phase equal to the last phase of the frame. It also rewrites a start phase in the middle of a frame and uses wrapping widths together with divider codes 0, 1, 2, 3 and 15. Every sampled cycle is judged against an arithmetic model: for each output cycle, the model searches back W cycles for a start phase, and it takes the frame index modulo N+1 to decide whether that frame fires.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int WID_W  = 8;
  localparam int RATE_W = 4;

  localparam logic [7:0] GP_DATA_A = 8'h20;
  localparam logic [7:0] GP_DIR_A  = 8'h21;
  localparam logic [7:0] GP_MASK_A = 8'h22;
  localparam logic [7:0] TMR_EN_A  = 8'h23;
  localparam logic [7:0] TMR_LO_A  = 8'h24;
  localparam logic [7:0] TMR_HI_A  = 8'h25;

  // divider step at a frame boundary: wraps to zero once the code is reached
  function automatic logic [RATE_W-1:0] fcnt_step(logic [RATE_W-1:0] cur,
                                                  logic [RATE_W-1:0] lim);
    return (cur >= lim) ? '0 : cur + 1'b1;
  endfunction

  // a frame fires when its divider count is zero
  function automatic logic frame_due(logic [RATE_W-1:0] cur);
    return cur == '0;
  endfunction

  // visible level of general-purpose bits
  function automatic logic [7:0] gpio_view(logic [7:0] dir, logic [7:0] dout,
                                           logic [7:0] pin, logic [7:0] mask);
    return mask & ((dir & dout) | (~dir & pin));
  endfunction
endpackage

// File: rtl/fpg_regs.sv
module fpg_regs
  import fpg_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int PHASE_W = 12,
  parameter int TMR_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [7:0]              addr,
  input  logic [7:0]              wdata,
  input  logic [NCH-1:0]          ch_in,
  output logic [NCH*PHASE_W-1:0]  ofs_flat,
  output logic [NCH*WID_W-1:0]    wid_flat,
  output logic [NCH*RATE_W-1:0]   rate_flat,
  output logic [NCH-1:0]          gp_mode,
  output logic [NCH-1:0]          inv,
  output logic [NCH-1:0]          gp_dout,
  output logic [NCH-1:0]          gp_dir,
  output logic [NCH-1:0]          gp_mask,
  output logic                    tmr_en,
  output logic [TMR_W-1:0]        tmr_reload,
  output logic [7:0]              rd_data
);
  localparam logic [15:0] OFS_MASK = 16'((32'd1 << PHASE_W) - 1);

  logic [15:0] ofs_r [NCH];
  logic [7:0]  wid_r [NCH];
  logic [7:0]  ctl_r [NCH];
  logic [15:0] rld_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        ofs_r[c] <= '0;
        wid_r[c] <= '0;
        ctl_r[c] <= '0;
      end
      gp_dout <= '0;
      gp_dir  <= '0;
      gp_mask <= '0;
      tmr_en  <= 1'b0;
      rld_r   <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < NCH; c++) begin
        if (addr[7:2] == 6'(c)) begin
          case (addr[1:0])
            2'd0: ofs_r[c][7:0]  <= wdata & OFS_MASK[7:0];
            2'd1: ofs_r[c][15:8] <= wdata & OFS_MASK[15:8];
            2'd2: wid_r[c]       <= wdata;
            default: ctl_r[c]    <= wdata;
          endcase
        end
      end
      case (addr)
        GP_DATA_A: gp_dout     <= wdata[NCH-1:0];
        GP_DIR_A:  gp_dir      <= wdata[NCH-1:0];
        GP_MASK_A: gp_mask     <= wdata[NCH-1:0];
        TMR_EN_A:  tmr_en      <= wdata[0];
        TMR_LO_A:  rld_r[7:0]  <= wdata;
        TMR_HI_A:  rld_r[15:8] <= wdata;
        default: ;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_flat
      assign ofs_flat[g*PHASE_W +: PHASE_W] = ofs_r[g][PHASE_W-1:0];
      assign wid_flat[g*WID_W +: WID_W]     = wid_r[g];
      assign rate_flat[g*RATE_W +: RATE_W]  = ctl_r[g][7:4];
      assign gp_mode[g]                     = ctl_r[g][0];
      assign inv[g]                         = ctl_r[g][1];
    end
  endgenerate

  assign tmr_reload = rld_r[TMR_W-1:0];

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr[7:2] == 6'(c)) begin
        case (addr[1:0])
          2'd0: rd_data = ofs_r[c][7:0];
          2'd1: rd_data = ofs_r[c][15:8];
          2'd2: rd_data = wid_r[c];
          default: rd_data = ctl_r[c];
        endcase
      end
    end
    case (addr)
      GP_DATA_A: rd_data = gpio_view(8'(gp_dir), 8'(gp_dout), 8'(ch_in), 8'(gp_mask));
      GP_DIR_A:  rd_data = 8'(gp_dir);
      GP_MASK_A: rd_data = 8'(gp_mask);
      TMR_EN_A:  rd_data = {7'd0, tmr_en};
      TMR_LO_A:  rd_data = rld_r[7:0];
      TMR_HI_A:  rd_data = rld_r[15:8];
      default: ;
    endcase
  end
endmodule

// File: rtl/fpg_chan.sv
module fpg_chan
  import fpg_pkg::*;
#(
  parameter int PHASE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase,
  input  logic               frame_tick,
  input  logic [PHASE_W-1:0] ofs_stage,
  input  logic [WID_W-1:0]   wid_stage,
  input  logic [RATE_W-1:0]  rate_stage,
  output logic [PHASE_W-1:0] ofs_act,
  output logic               start,
  output logic               pulse
);
  logic [WID_W-1:0]  wid_act;
  logic [RATE_W-1:0] rate_act;
  logic [RATE_W-1:0] fcnt;
  logic [WID_W-1:0]  remain;

  assign start = (phase == ofs_act) && frame_due(fcnt) && (wid_act != '0);

  // staged settings and frame divider move only on the frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_act  <= '0;
      wid_act  <= '0;
      rate_act <= '0;
      fcnt     <= '0;
    end else if (frame_tick) begin
      ofs_act  <= ofs_stage;
      wid_act  <= wid_stage;
      rate_act <= rate_stage;
      fcnt     <= fcnt_step(fcnt, rate_act);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      remain <= '0;
    end else if (start) begin
      pulse  <= 1'b1;
      remain <= wid_act - 1'b1;
    end else if (pulse) begin
      if (remain == '0) pulse <= 1'b0;
      else remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/fpg_timer.sv
module fpg_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [TMR_W-1:0] reload,
  output logic [TMR_W-1:0] cnt,
  output logic             pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (!en) begin
      cnt   <= reload;
      pulse <= 1'b0;
    end else if (cnt == '0) begin
      cnt   <= reload;
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt - 1'b1;
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/fpulse_gen.sv
module fpulse_gen
  import fpg_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int PHASE_W = 12,
  parameter int TMR_W   = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [7:0]     addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rd_data,
  input  logic [NCH-1:0] ch_in,
  output logic [NCH-1:0] ch_out,
  output logic [NCH-1:0] ch_oe
);
  logic [PHASE_W-1:0]      phase;
  logic                    frame_tick;
  logic [NCH*PHASE_W-1:0]  ofs_stage_flat;
  logic [NCH*PHASE_W-1:0]  ofs_act_flat;
  logic [NCH*WID_W-1:0]    wid_flat;
  logic [NCH*RATE_W-1:0]   rate_flat;
  logic [NCH-1:0]          gp_mode, inv, gp_dout, gp_dir, gp_mask;
  logic [NCH-1:0]          chan_start, chan_pulse, tsel;
  logic                    tmr_en, tmr_pulse;
  logic [TMR_W-1:0]        tmr_reload, tmr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  assign frame_tick = &phase;

  fpg_regs #(.NCH(NCH), .PHASE_W(PHASE_W), .TMR_W(TMR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ch_in(ch_in), .ofs_flat(ofs_stage_flat), .wid_flat(wid_flat),
    .rate_flat(rate_flat), .gp_mode(gp_mode), .inv(inv), .gp_dout(gp_dout),
    .gp_dir(gp_dir), .gp_mask(gp_mask), .tmr_en(tmr_en),
    .tmr_reload(tmr_reload), .rd_data(rd_data)
  );

  fpg_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .reload(tmr_reload),
    .cnt(tmr_cnt), .pulse(tmr_pulse)
  );

  assign tsel = {tmr_en, {(NCH-1){1'b0}}};

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic src;
      logic gp_own;

      fpg_chan #(.PHASE_W(PHASE_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .phase(phase), .frame_tick(frame_tick),
        .ofs_stage(ofs_stage_flat[c*PHASE_W +: PHASE_W]),
        .wid_stage(wid_flat[c*WID_W +: WID_W]),
        .rate_stage(rate_flat[c*RATE_W +: RATE_W]),
        .ofs_act(ofs_act_flat[c*PHASE_W +: PHASE_W]),
        .start(chan_start[c]), .pulse(chan_pulse[c])
      );

      assign src       = tsel[c] ? tmr_pulse : chan_pulse[c];
      assign gp_own    = gp_mode[c] & ~tsel[c];
      assign ch_out[c] = gp_own ? gp_dout[c] : (src ^ inv[c]);
      assign ch_oe[c]  = gp_own ? gp_dir[c] : 1'b1;
    end
  endgenerate
endmodule

// File: rtl/fpulse_gen_chk.sv
module fpulse_gen_chk #(
  parameter int NCH     = 8,
  parameter int PHASE_W = 12,
  parameter int TMR_W   = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [7:0]             addr,
  input logic [7:0]             rd_data,
  input logic [NCH-1:0]         gp_mask,
  input logic [NCH-1:0]         gp_mode,
  input logic [NCH-1:0]         ch_oe,
  input logic                   frame_tick,
  input logic [NCH*PHASE_W-1:0] ofs_act_flat,
  input logic [NCH-1:0]         chan_start,
  input logic [NCH-1:0]         chan_pulse,
  input logic                   tmr_pulse,
  input logic [TMR_W-1:0]       tmr_cnt
);
  localparam logic [15:0] OFS_MASK = 16'((32'd1 << PHASE_W) - 1);

  // R5
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(ofs_act_flat));

  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_start) |=> ((chan_pulse & $past(chan_start)) == $past(chan_start)));

  // R9
  tmr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_pulse |-> ($past(tmr_cnt) == '0));

  // R8
  read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h20) |-> ((rd_data & ~8'(gp_mask)) == 8'h00));

  // R7
  frame_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~gp_mode & ~ch_oe) == '0));

  // R6
  ofs_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr < 8'(NCH*4)) && (addr[1:0] == 2'd1)) |-> ((rd_data & ~OFS_MASK[15:8]) == 8'h00));
endmodule

bind fpulse_gen fpulse_gen_chk #(.NCH(NCH), .PHASE_W(PHASE_W), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_data(rd_data), .gp_mask(gp_mask),
  .gp_mode(gp_mode), .ch_oe(ch_oe), .frame_tick(frame_tick),
  .ofs_act_flat(ofs_act_flat), .chan_start(chan_start), .chan_pulse(chan_pulse),
  .tmr_pulse(tmr_pulse), .tmr_cnt(tmr_cnt)
);

// File: tb/fpulse_gen_test.sv
`timescale 1ns/1ps
module fpulse_gen_test;
  localparam int NCH = 8;
  localparam int PW  = 6;
  localparam int F   = 1 << PW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [7:0]     addr = 8'h00;
  logic [7:0]     wdata = 8'h00;
  logic [7:0]     rd_data;
  logic [NCH-1:0] ch_in = '0;
  logic [NCH-1:0] ch_out, ch_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  fpulse_gen #(.NCH(NCH), .PHASE_W(PW), .TMR_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .ch_in(ch_in), .ch_out(ch_out), .ch_oe(ch_oe)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    #2;
    v = rd_data;
  endtask

  // is the pulse high in cycle n? a start at cycle s covers cycles s+1 .. s+w
  function automatic bit exp_hi(int n, int a1, int a2, int sw, int w, int r);
    int f, aa;
    for (int s = n - w; s < n; s++) begin
      if (s >= F) begin
        f  = s / F;
        aa = (f < sw) ? a1 : a2;
        if ((s % F) == aa && ((f - 1) % (r + 1)) == 0) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic run_pulse(input int ch, input int a, input int w, input int r,
                           input bit inv, input int a2, input string req);
    int nfr, bad, fa, fe;
    logic [NCH-1:0] e;
    do_reset();
    wr(8'(ch*4), 8'(a));
    wr(8'(ch*4+1), 8'(a >> 8));
    wr(8'(ch*4+2), 8'(w));
    wr(8'(ch*4+3), {4'(r), 2'b00, inv, 1'b0});
    nfr = 2 + 2 * (r + 1);
    if (a2 >= 0 && nfr < 4) nfr = 4;
    bad = 0; fa = 0; fe = 0;
    while (cyc < nfr * F) begin
      @(negedge clk);
      if (a2 >= 0 && cyc == F + 10) begin
        addr = 8'(ch*4); wdata = 8'(a2); wr_en = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
      e = '0;
      e[ch] = exp_hi(cyc, a, (a2 >= 0) ? a2 : a, 2, w, r) ^ inv;
      if ({ch_oe, ch_out} != {{NCH{1'b1}}, e} && bad == 0) begin
        bad = 1; fa = int'({ch_oe, ch_out}); fe = int'({{NCH{1'b1}}, e});
      end
    end
    wr_en = 1'b0;
    check(bad == 0, req, fa, fe);
  endtask

  task automatic run_timer(input int rl, input int ncyc);
    int last, gap_bad, wid_bad, prev, rises;
    last = -1; gap_bad = 0; wid_bad = 0; prev = 0; rises = 0;
    do_reset();
    wr(8'h24, 8'(rl));
    wr(8'h25, 8'(rl >> 8));
    wr(8'h23, 8'h01);
    repeat (ncyc) begin
      @(negedge clk);
      if (ch_out[7] && prev == 1) wid_bad++;
      if (ch_out[7] && prev == 0) begin
        if (last >= 0 && cyc - last != rl + 1) gap_bad++;
        last = cyc;
        rises++;
      end
      prev = ch_out[7];
    end
    check(gap_bad == 0 && rises >= 2, "R9 timer spacing", gap_bad, 0);
    check(wid_bad == 0, "R9 timer one-cycle pulse", wid_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, ex;

    // R10: reset state
    do_reset();
    @(negedge clk);
    check(ch_out == '0, "R10 reset ch_out", ch_out, 0);
    check(ch_oe == '1, "R10 reset ch_oe", ch_oe, 8'hFF);
    rd(8'h0E, v); check(v == 8'h00, "R10 reset width reg", v, 0);
    rd(8'h24, v); check(v == 8'h00, "R10 reset reload reg", v, 0);

    // R1: start phase and width on every channel
    run_pulse(0, 5, 3, 0, 0, -1, "R1 ch0");
    run_pulse(1, 0, 1, 0, 0, -1, "R1 ch1 start zero");
    run_pulse(2, 17, 10, 0, 0, -1, "R1 ch2");
    run_pulse(3, 33, 7, 0, 0, -1, "R1 ch3");
    run_pulse(4, 50, 2, 0, 0, -1, "R1 ch4");
    run_pulse(5, 8, 20, 0, 0, -1, "R1 ch5");
    run_pulse(6, 41, 1, 0, 0, -1, "R1 ch6");
    run_pulse(7, 25, 4, 0, 0, -1, "R1 ch7");
    // R2: wrap across boundary, last phase, zero width, long pulse
    run_pulse(2, 62, 5, 0, 0, -1, "R2 wrap");
    run_pulse(3, 63, 1, 0, 0, -1, "R2 last phase");
    run_pulse(4, 10, 0, 0, 0, -1, "R2 zero width");
    run_pulse(5, 60, 30, 1, 0, -1, "R2 long wrap");
    // R3: inversion
    run_pulse(1, 12, 6, 0, 1, -1, "R3 invert");
    run_pulse(7, 63, 3, 1, 1, -1, "R3 invert wrap");
    // R4: frame divider
    run_pulse(6, 20, 4, 1, 0, -1, "R4 rate1");
    run_pulse(0, 7, 3, 3, 0, -1, "R4 rate3");
    run_pulse(7, 44, 9, 2, 0, -1, "R4 rate2");
    run_pulse(1, 3, 2, 15, 0, -1, "R4 rate15");
    // R5: mid-frame rewrite lands at the next boundary
    run_pulse(3, 40, 3, 0, 0, 20, "R5 late rewrite");
    run_pulse(2, 63, 2, 0, 0, 5, "R5 rewrite with boundary start");

    // R6: start bytes masked to PHASE_W
    do_reset();
    wr(8'h08, 8'hFF); rd(8'h08, v);
    ex = 8'((1 << PW) - 1);
    check(v == ex, "R6 low start byte", v, ex);
    wr(8'h09, 8'hFF); rd(8'h09, v);
    check(v == 8'h00, "R6 high start byte", v, 0);
    // R10: readback
    wr(8'h0E, 8'hAB); rd(8'h0E, v); check(v == 8'hAB, "R10 width readback", v, 8'hAB);
    wr(8'h13, 8'h5C); rd(8'h13, v); check(v == 8'h5C, "R10 control readback", v, 8'h5C);

    // R7, R8: general-purpose mode
    do_reset();
    for (int c = 0; c < NCH; c++) wr(8'(c*4+3), 8'h01);
    wr(8'h21, 8'h0F); wr(8'h20, 8'hA5); wr(8'h22, 8'hF3);
    ch_in = 8'h5C;
    @(negedge clk);
    check(ch_out == 8'hA5, "R7 gpio out", ch_out, 8'hA5);
    check(ch_oe == 8'h0F, "R7 gpio oe", ch_oe, 8'h0F);
    rd(8'h20, v);
    ex = 8'hF3 & ((8'h0F & 8'hA5) | (8'hF0 & 8'h5C));
    check(v == ex, "R8 gpio read", v, ex);
    wr(8'h22, 8'h00); rd(8'h20, v);
    check(v == 8'h00, "R8 mask all off", v, 0);
    wr(8'h0F, 8'h00);
    @(negedge clk);
    check(ch_oe == 8'h0F && ch_out == 8'hA5, "R7 frame mode oe high",
          int'(ch_oe), 8'h0F);
    check(ch_oe[3] == 1'b1 && ch_out[3] == 1'b0, "R7 ch3 frame mode", ch_oe[3], 1);

    // R9: timer
    run_timer(5, 100);
    run_timer(258, 800);
    rd(8'h25, v); check(v == 8'h01, "R9 reload high byte", v, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule